// File: doc/BRIEF.md
# Multichannel ADC Serial Output Framer

This block sits between the parallel outputs of a bank of converter channels and their serial output lanes. In each frame it takes one 12-bit word per channel and sends each channel's word on its own lane, most significant bit first. The block runs from a single bit-rate clock at twelve times the sample rate. It also produces two timing signals for the receiver. The first is a frame marker at the sample rate that is high during the first half of every word. The second is a forwarded data clock at six times the sample rate. The forwarded clock changes state in the middle of every bit slot, so a receiver can capture one bit on each of its rising and falling edges.

Words are offered on a shared parallel bus together with a one-cycle valid strobe. A word can arrive at any point in a frame. It is held and sent, on all lanes together, starting at the next frame boundary. If no new word arrives, the held word is sent again. A coding select can convert each word from offset binary to twos complement just before serialization. In offset binary, code 4095 is positive full scale, 2048 is mid-scale and 0 is negative full scale. Twos complement is formed by flipping the top bit.

Top module: `adc_lane_framer`

## Requirements
- R1: While `rst_n` is low, `frame_out`, `dclk_out` and every bit of `lane_data` are 0. The held word of every lane resets to 0.
- R2: After reset, `frame_out` repeats with a period of exactly 12 clock cycles. It is high for the first 6 bit slots of each word and low for the last 6. It first rises on the first rising clock edge after reset is released.
- R3: `dclk_out` changes state on every falling clock edge, which is the middle of each bit slot. This gives exactly 6 rising edges of `dclk_out` per frame.
- R4: Each lane sends its word most significant bit first. Bit slot k of a frame (k = 0 for the first slot with `frame_out` high) carries bit 11-k of the word.
- R5: All lanes start their words in the same bit slot. Lane i carries bits [12*i+11 : 12*i] of `samples`.
- R6: With `twos_mode` = 0, the serialized word equals the captured offset-binary word unchanged.
- R7: With `twos_mode` = 1, the serialized word is the captured word with bit 11 inverted, so 2048 becomes 0 and 4095 becomes 2047. `twos_mode` is sampled on the last clock cycle of a frame, when the next word is loaded.
- R8: A rising clock edge with `sample_valid` = 1 captures `samples` into the held words. A word captured at any edge of a frame, including the edge in its last slot, is sent in the frame that follows. If several words are captured in one frame, the last one is sent.
- R9: A frame that begins with no new word captured since the previous frame boundary sends the same word again on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, twelve times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| twos_mode | input | 1 | 1 selects twos complement output coding, 0 selects offset binary |
| sample_valid | input | 1 | Strobe marking a new set of channel words on `samples` |
| samples | input | NUM_LANES*12 | Parallel channel words, lane 0 in the low bits |
| lane_data | output | NUM_LANES | One serial data bit per lane |
| dclk_out | output | 1 | Forwarded data clock, toggling in the middle of each bit slot |
| frame_out | output | 1 | Frame marker, high for the first half of each word |

## Verification
The assertions assume that `rst_n` is released well away from either clock edge. This matters because the forwarded-clock register samples reset on the falling edge while everything else samples it on the rising edge. They also assume that `samples` is stable in any cycle where `sample_valid` is high. The stimulus changes every input on falling clock edges and releases reset one time unit after a rising edge. It also changes `twos_mode` only together with a new word, so the coding applied to a repeated frame always matches the coding of the word that was last loaded.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;

    // Output coding applied when a held word is loaded into the shifter
    typedef enum logic {
        CODE_OFFSET = 1'b0,
        CODE_TWOS   = 1'b1
    } code_e;

    // Default sample word width
    localparam int unsigned DEF_WORD_W = 12;

    // Default number of serial lanes
    localparam int unsigned DEF_LANES = 4;

endpackage

// File: rtl/adc_framer_slot_timer.sv
module adc_framer_slot_timer #(
    parameter int WORD_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic frame_o
);
    localparam int SLOT_W = $clog2(WORD_W);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_HALF = SLOT_W'(WORD_W / 2);
    localparam logic [SLOT_W-1:0] SLOT_ONE  = SLOT_W'(1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              frame;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == SLOT_LAST) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + SLOT_ONE;
        end
        // marker covers the first half of the word
        st_d.frame = (st_d.slot < SLOT_HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot  <= SLOT_LAST;
            st_q.frame <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // the shifters load on the edge that closes the last slot
    assign load_o  = (st_q.slot == SLOT_LAST);
    assign frame_o = st_q.frame;

endmodule

// File: rtl/adc_framer_lane.sv
module adc_framer_lane
    import adc_framer_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              twos_i,
    input  logic              load_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              ser_o
);
    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] shift;
    } lane_t;

    lane_t ln_d, ln_q;
    code_e code;

    assign code = code_e'(twos_i);

    always_comb begin
        ln_d = ln_q;
        if (valid_i) begin
            ln_d.hold = word_i;
        end
        if (load_i) begin
            // a word captured on the load edge still makes this frame
            ln_d.shift = ln_d.hold;
            if (code == CODE_TWOS) begin
                ln_d.shift[WORD_W-1] = ~ln_d.hold[WORD_W-1];
            end
        end else begin
            ln_d.shift = {ln_q.shift[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign hold_o = ln_q.hold;
    assign ser_o  = ln_q.shift[WORD_W-1];

endmodule

// File: rtl/adc_framer_dclk.sv
module adc_framer_dclk (
    input  logic clk,
    input  logic rst_n,
    output logic dclk_o
);
    logic dclk_d, dclk_q;

    always_comb begin
        dclk_d = ~dclk_q;
    end

    // falling-edge register puts both data clock edges mid-slot
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            dclk_q <= 1'b0;
        end else begin
            dclk_q <= dclk_d;
        end
    end

    assign dclk_o = dclk_q;

endmodule

// File: rtl/adc_lane_framer.sv
module adc_lane_framer #(
    parameter int NUM_LANES = 4,
    parameter int WORD_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          twos_mode,
    input  logic                          sample_valid,
    input  logic [NUM_LANES*WORD_W-1:0]   samples,
    output logic [NUM_LANES-1:0]          lane_data,
    output logic                          dclk_out,
    output logic                          frame_out
);
    localparam int BUS_W = NUM_LANES * WORD_W;

    logic             load;
    logic [BUS_W-1:0] lane_hold;

    adc_framer_slot_timer #(
        .WORD_W (WORD_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_o  (load),
        .frame_o (frame_out)
    );

    adc_framer_dclk i_dclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .dclk_o (dclk_out)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        adc_framer_lane #(
            .WORD_W (WORD_W)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (sample_valid),
            .word_i  (samples[g*WORD_W +: WORD_W]),
            .twos_i  (twos_mode),
            .load_i  (load),
            .hold_o  (lane_hold[g*WORD_W +: WORD_W]),
            .ser_o   (lane_data[g])
        );
    end

endmodule

// File: rtl/adc_lane_framer_chk.sv
module adc_lane_framer_chk #(
    parameter int NUM_LANES = 4,
    parameter int WORD_W    = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frame_out,
    input logic                        dclk_out,
    input logic                        sample_valid,
    input logic [NUM_LANES*WORD_W-1:0] samples,
    input logic [NUM_LANES*WORD_W-1:0] lane_hold
);
    localparam logic [15:0] PERIOD = 16'(WORD_W);
    localparam logic [15:0] HIGH_N = 16'(WORD_W / 2);

    logic        prev_frame;
    logic        seen_rise;
    logic [15:0] since_rise;
    logic [15:0] high_cnt;
    logic        rise_now;
    logic        fall_now;

    assign rise_now = frame_out && !prev_frame;
    assign fall_now = !frame_out && prev_frame;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_frame <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
            high_cnt   <= '0;
        end else begin
            prev_frame <= frame_out;
            seen_rise  <= seen_rise | rise_now;
            since_rise <= rise_now ? 16'd1 : since_rise + 16'd1;
            high_cnt   <= frame_out ? high_cnt + 16'd1 : 16'd0;
        end
    end

    // R2
    frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && seen_rise) |-> (since_rise == PERIOD));

    // R2
    frame_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_now |-> (high_cnt == HIGH_N));

    // R3
    dclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dclk_out != $past(dclk_out)));

    // R8
    sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> (lane_hold == $past(samples)));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(lane_hold));

endmodule

bind adc_lane_framer adc_lane_framer_chk #(
    .NUM_LANES (NUM_LANES),
    .WORD_W    (WORD_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_out    (frame_out),
    .dclk_out     (dclk_out),
    .sample_valid (sample_valid),
    .samples      (samples),
    .lane_hold    (lane_hold)
);

// File: tb/test_adc_lane_framer.sv
module test_adc_lane_framer;
    localparam int NL  = 4;
    localparam int W   = 12;
    localparam int TOT = NL * W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           twos_mode = 1'b0;
    logic           sample_valid = 1'b0;
    logic [TOT-1:0] samples = '0;
    logic [NL-1:0]  lane_data;
    logic           dclk_out;
    logic           frame_out;

    adc_lane_framer #(.NUM_LANES(NL), .WORD_W(W)) i_adc_lane_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .twos_mode    (twos_mode),
        .sample_valid (sample_valid),
        .samples      (samples),
        .lane_data    (lane_data),
        .dclk_out     (dclk_out),
        .frame_out    (frame_out)
    );

    always #4 clk = ~clk;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    typedef struct {
        int             tag;
        bit             mode;
        logic [TOT-1:0] w;
    } item_t;
    item_t sb_q[$];

    function automatic logic [W-1:0] enc(input logic [W-1:0] v, input bit md);
        return {v[W-1] ^ md, v[W-2:0]};
    endfunction

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // frame marker and data clock timing, sampled just after each rising edge
    int fcnt = 0;
    bit fprev = 1'b0;
    int cyc = 0;
    int hi = 0;
    int drise = 0;

    always @(posedge dclk_out) drise++;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            if (frame_out) hi++;
            if (frame_out && !fprev) begin
                if (fcnt > 0) begin
                    n_checks += 2;
                    if (cyc != W) begin
                        n_fail++;
                        $display("FAIL R2 frame period got %0d exp %0d", cyc, W);
                    end
                    if (drise != W / 2) begin
                        n_fail++;
                        $display("FAIL R3 data clock rises per frame got %0d exp %0d", drise, W / 2);
                    end
                end
                fcnt++;
                cyc = 0;
                drise = 0;
            end
            if (!frame_out && fprev) begin
                n_checks++;
                if (hi != W / 2) begin
                    n_fail++;
                    $display("FAIL R2 frame high length got %0d exp %0d", hi, W / 2);
                end
                hi = 0;
            end
            fprev = frame_out;
        end
    end

    // monitor: deserialize every lane on both data clock edges
    logic [W-1:0]   acc [NL];
    logic [TOT-1:0] last_w = '0;
    bit             mprev = 1'b0;
    int             widx = 0;
    int             nbits = 0;

    always @(dclk_out) begin
        if (rst_n) begin
            if (frame_out && !mprev) begin
                widx++;
                nbits = 0;
            end
            mprev = frame_out;
            if (widx > 0) begin
                for (int l = 0; l < NL; l++) acc[l] = {acc[l][W-2:0], lane_data[l]};
                nbits++;
                if (nbits == W) begin
                    logic [TOT-1:0] expw;
                    string          tg;
                    if (sb_q.size() > 0 && sb_q[0].tag < widx) begin
                        item_t lost;
                        lost = sb_q.pop_front();
                        n_checks++;
                        n_fail++;
                        $display("FAIL R8 word for frame %0d not seen got frame %0d exp frame %0d",
                                 lost.tag, widx, lost.tag);
                    end
                    if (sb_q.size() > 0 && sb_q[0].tag == widx) begin
                        item_t it;
                        it = sb_q.pop_front();
                        for (int l = 0; l < NL; l++)
                            expw[l*W +: W] = enc(it.w[l*W +: W], it.mode);
                        tg = it.mode ? "R7" : "R6";
                    end else begin
                        expw = last_w;
                        tg = "R9";
                    end
                    last_w = expw;
                    // R4 bit order and R5 lane mapping are covered by every comparison
                    for (int l = 0; l < NL; l++) begin
                        n_checks++;
                        if (acc[l] !== expw[l*W +: W]) begin
                            n_fail++;
                            $display("FAIL %s/R4/R5 lane %0d frame %0d got %h exp %h",
                                     tg, l, widx, acc[l], expw[l*W +: W]);
                        end
                    end
                end
            end
        end
    end

    // driver: offer a word (or two, last wins) at a slot offset inside a frame
    task automatic send(input logic [TOT-1:0] w1, input logic [TOT-1:0] w2,
                        input bit md, input int off, input bit pair);
        int    f0;
        item_t it;
        f0 = fcnt;
        wait (fcnt != f0);
        repeat (off + 1) @(negedge clk);
        it.tag = fcnt + 1;
        it.mode = md;
        twos_mode = md;
        sample_valid = 1'b1;
        samples = w1;
        @(negedge clk);
        if (pair) begin
            samples = w2;
            @(negedge clk);
        end
        sample_valid = 1'b0;
        it.w = pair ? w2 : w1;
        sb_q.push_back(it);
    endtask

    function automatic logic [TOT-1:0] rnd_bus();
        logic [TOT-1:0] v;
        for (int l = 0; l < NL; l++) v[l*W +: W] = W'($urandom);
        return v;
    endfunction

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got running exp finished");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_checks++;
        // R1: outputs quiet while reset is held
        if (frame_out !== 1'b0 || dclk_out !== 1'b0 || lane_data !== '0) begin
            n_fail++;
            $display("FAIL R1 reset outputs got %b%b%h exp 000",
                     frame_out, dclk_out, lane_data);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // scale points, offset binary, mid-frame arrival
        send({12'h7FF, 12'h000, 12'hFFF, 12'h800}, '0, 1'b0, 3, 1'b0);
        // same points as twos complement, arriving in the last slot
        send({12'h7FF, 12'h000, 12'hFFF, 12'h800}, '0, 1'b1, 11, 1'b0);
        // one hot and alternating patterns at the first slot
        send({12'h001, 12'hAAA, 12'h555, 12'h800}, '0, 1'b0, 0, 1'b0);
        send({12'hA33, 12'h03F, 12'hFFF, 12'h000}, '0, 1'b1, 0, 1'b0);
        // two words in one frame, the later one is sent
        send({12'h123, 12'h456, 12'h789, 12'hABC}, {12'hFED, 12'hCBA, 12'h987, 12'h654},
             1'b0, 5, 1'b1);
        send(rnd_bus(), rnd_bus(), 1'b1, 10, 1'b1);
        // idle frames repeat the held word
        repeat (40) @(posedge clk);
        for (int k = 0; k < 12; k++) begin
            send(rnd_bus(), '0, k[0], (k * 5) % 12, 1'b0);
            if (k % 4 == 3) repeat (30) @(posedge clk);
        end
        wait (sb_q.size() == 0);
        repeat (60) @(posedge clk);
        report();
    end

endmodule